// File: doc/BRIEF.md
# MOESI Snooping Coherence Controller

This block keeps the coherence state of every line in a small directly indexed cache that sits on a shared snooping bus. It takes processor requests (read, write, evict) for one line index at a time and turns them into bus commands: read, read-for-ownership, upgrade and writeback. It also watches the commands other caches place on the bus and answers them. It can source data, assert the shared signal, or invalidate its own copy. Data storage, tag matching, bus arbitration and memory sit outside the block.

Alongside Modified, Exclusive, Shared and Invalid, the block has an Owned state. A dirty line can therefore be passed to other readers without a memory writeback. The cache that holds the line Owned supplies the data to later readers. It is also the only cache that writes the line back, and it does so when it evicts the line. One parameter chooses who keeps ownership when another cache reads an Owned or Modified line. A second parameter removes the Exclusive state, which leaves a 2-bit state encoding.

Each request is handled in one cycle. The bus answers the requester's snoop responses (shared, sourced-by-cache) in the same cycle as the request. The bus command, the strobes and the new line state are all visible one cycle later.

Top module: `moesi_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid (code 0). When no request is valid, `bus_cmd_o` is idle (code 0) and `wb_o`, `flush_o` and `shared_o` are low in the following cycle.
- R2: A processor read (op code 0) to an Invalid line issues a bus read (command code 1). The line fills Exclusive (code 4) when neither `bus_shared_i` nor `bus_src_i` is high, and Shared (code 1) otherwise.
- R3: A processor write (op code 1) to an Invalid line issues read-for-ownership (command code 2) and fills Modified (code 3). A write to an Exclusive line moves it to Modified with no bus command. A write to a Modified line issues nothing.
- R4: A processor write to a Shared or Owned (code 2) line issues an upgrade (command code 3) and moves the line to Modified.
- R5: A snooped bus read to a Modified line raises `flush_o` and `shared_o` without `wb_o`. The line moves to Owned under hand-off policy 0, or to Shared under policy 1.
- R6: A snooped bus read to an Owned line raises `flush_o` and `shared_o`. The line stays Owned under policy 0 and drops to Shared under policy 1. A snooped read to an Exclusive or Shared line raises only `shared_o` and leaves the line Shared.
- R7: A snooped read-for-ownership or upgrade invalidates the line. Modified and Owned lines also raise `flush_o`. Exclusive and Shared lines do not.
- R8: Evicting (op code 2) a Modified or Owned line issues a writeback (command code 4) with `wb_o` high and leaves it Invalid. Evicting an Exclusive or Shared line invalidates it silently. `wb_o` is never high without a writeback command.
- R9: Exclusive and Shared lines never move to Owned. A read miss fills Owned only under policy 1.
- R10: Under hand-off policy 1, a read miss during which another cache sourced the data (`bus_src_i` high) fills Owned, so the requester inherits ownership.
- R11: With the Exclusive state disabled, the state port is 2 bits wide and a read miss with no sharers fills Shared.
- R12: A snooped writeback (command code 4), or any snoop to an Invalid line, drives no response and leaves the line unchanged.
- R13: A processor read to a valid line issues no bus command and leaves its state. Processor and snoop requests arrive in different cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| preq_valid_i | input | 1 | Processor request valid |
| preq_op_i | input | 2 | 0 read, 1 write, 2 evict |
| preq_idx_i | input | IDX_W | Line index of the processor request |
| bus_shared_i | input | 1 | Another cache holds the line (response to own bus read) |
| bus_src_i | input | 1 | Another cache sourced the fill data (response to own bus read) |
| snp_valid_i | input | 1 | Snooped command from another cache valid |
| snp_cmd_i | input | 3 | Snooped command: 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| snp_idx_i | input | IDX_W | Line index of the snooped command |
| st_rd_idx_i | input | IDX_W | Line index for the state lookup port |
| st_rd_o | output | ST_W | Current state of line `st_rd_idx_i` |
| bus_cmd_o | output | 3 | Issued bus command: 0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| wb_o | output | 1 | Memory writeback strobe |
| flush_o | output | 1 | This cache sources line data to the bus |
| shared_o | output | 1 | This cache holds a copy of the snooped line |

## Verification
The assertions assume two things about the inputs. Processor and snoop requests never share a cycle. The same-cycle `bus_shared_i` and `bus_src_i` responses describe what the other caches really hold. The stimulus drives one request every other cycle and never sets the two valids together. It only raises `bus_src_i` for reads in which a dirty owner elsewhere would supply the line. Two instances with opposite hand-off policies and Exclusive settings get identical stimulus and are compared against separately derived expectations.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    ST_I = 3'd0,
    ST_S = 3'd1,
    ST_O = 3'd2,
    ST_M = 3'd3,
    ST_E = 3'd4
  } line_st_e;

  typedef enum logic [2:0] {
    BC_NONE = 3'd0,
    BC_RD   = 3'd1,
    BC_RDX  = 3'd2,
    BC_UPGR = 3'd3,
    BC_WB   = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2
  } proc_op_e;
endpackage

// File: rtl/moesi_state_array.sv
module moesi_state_array #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned SW        = 3,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [SW-1:0]    wst_i,
  output logic [SW-1:0]    st_o [NUM_LINES]
);
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       st_o[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))              st_o[g] <= wst_i;
    end
  end
endmodule

// File: rtl/moesi_proc_fsm.sv
module moesi_proc_fsm
  import moesi_pkg::*;
#(
  parameter bit HAS_EXCL = 1'b1,
  parameter bit HANDOFF  = 1'b0
) (
  input  proc_op_e op_i,
  input  line_st_e cur_i,
  input  logic     shared_i,
  input  logic     src_i,
  output line_st_e nxt_o,
  output bus_cmd_e cmd_o,
  output logic     wb_o
);
  always_comb begin
    nxt_o = cur_i;
    cmd_o = BC_NONE;
    wb_o  = 1'b0;
    unique case (op_i)
      OP_READ: begin
        if (cur_i == ST_I) begin
          cmd_o = BC_RD;
          if (HANDOFF && src_i)                       nxt_o = ST_O;
          else if (shared_i || src_i || !HAS_EXCL)    nxt_o = ST_S;
          else                                        nxt_o = ST_E;
        end
      end
      OP_WRITE: begin
        unique case (cur_i)
          ST_I:       begin cmd_o = BC_RDX;  nxt_o = ST_M; end
          ST_S, ST_O: begin cmd_o = BC_UPGR; nxt_o = ST_M; end
          ST_E:       nxt_o = ST_M;
          default:    nxt_o = cur_i;
        endcase
      end
      OP_EVICT: begin
        if (cur_i == ST_M || cur_i == ST_O) begin
          cmd_o = BC_WB;
          wb_o  = 1'b1;
        end
        nxt_o = ST_I;
      end
      default: nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/moesi_snoop_fsm.sv
module moesi_snoop_fsm
  import moesi_pkg::*;
#(
  parameter bit HANDOFF = 1'b0
) (
  input  bus_cmd_e scmd_i,
  input  line_st_e cur_i,
  output line_st_e nxt_o,
  output logic     flush_o,
  output logic     shared_o
);
  logic dirty;
  assign dirty = (cur_i == ST_M) || (cur_i == ST_O);

  always_comb begin
    nxt_o    = cur_i;
    flush_o  = 1'b0;
    shared_o = 1'b0;
    unique case (scmd_i)
      BC_RD: begin
        if (dirty) begin
          flush_o  = 1'b1;
          shared_o = 1'b1;
          nxt_o    = HANDOFF ? ST_S : ST_O;
        end else if (cur_i != ST_I) begin
          shared_o = 1'b1;
          nxt_o    = ST_S;
        end
      end
      BC_RDX, BC_UPGR: begin
        flush_o = dirty;
        nxt_o   = ST_I;
      end
      default: nxt_o = cur_i;  // writebacks are ignored
    endcase
  end
endmodule

// File: rtl/moesi_coh_ctrl.sv
module moesi_coh_ctrl
  import moesi_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter bit          HAS_EXCL  = 1'b1,
  parameter bit          HANDOFF   = 1'b0,
  localparam int unsigned IDX_W    = $clog2(NUM_LINES),
  localparam int unsigned ST_W     = HAS_EXCL ? 3 : 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preq_valid_i,
  input  logic [1:0]       preq_op_i,
  input  logic [IDX_W-1:0] preq_idx_i,
  input  logic             bus_shared_i,
  input  logic             bus_src_i,
  input  logic             snp_valid_i,
  input  logic [2:0]       snp_cmd_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  input  logic [IDX_W-1:0] st_rd_idx_i,
  output logic [ST_W-1:0]  st_rd_o,
  output logic [2:0]       bus_cmd_o,
  output logic             wb_o,
  output logic             flush_o,
  output logic             shared_o
);
  logic [ST_W-1:0] st_raw [NUM_LINES];
  line_st_e        line_st [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ext
    if (ST_W == 3) begin : g_w3
      assign line_st[g] = line_st_e'(st_raw[g]);
    end else begin : g_w2
      assign line_st[g] = line_st_e'({1'b0, st_raw[g]});
    end
  end

  line_st_e cur_p, cur_s, nxt_p, nxt_s;
  bus_cmd_e cmd_p;
  logic     wb_p, fl_s, sh_s;

  assign cur_p = line_st[preq_idx_i];
  assign cur_s = line_st[snp_idx_i];

  moesi_proc_fsm #(.HAS_EXCL(HAS_EXCL), .HANDOFF(HANDOFF)) u_proc (
    .op_i     (proc_op_e'(preq_op_i)),
    .cur_i    (cur_p),
    .shared_i (bus_shared_i),
    .src_i    (bus_src_i),
    .nxt_o    (nxt_p),
    .cmd_o    (cmd_p),
    .wb_o     (wb_p)
  );

  moesi_snoop_fsm #(.HANDOFF(HANDOFF)) u_snoop (
    .scmd_i   (bus_cmd_e'(snp_cmd_i)),
    .cur_i    (cur_s),
    .nxt_o    (nxt_s),
    .flush_o  (fl_s),
    .shared_o (sh_s)
  );

  // processor side wins the single write port; arbitration keeps them apart
  logic             we;
  logic [IDX_W-1:0] widx;
  line_st_e         wst;
  always_comb begin
    we   = preq_valid_i | snp_valid_i;
    widx = preq_valid_i ? preq_idx_i : snp_idx_i;
    wst  = preq_valid_i ? nxt_p : nxt_s;
  end

  moesi_state_array #(.NUM_LINES(NUM_LINES), .SW(ST_W)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .widx_i (widx),
    .wst_i  (wst[ST_W-1:0]),
    .st_o   (st_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_cmd_o <= BC_NONE;
      wb_o      <= 1'b0;
      flush_o   <= 1'b0;
      shared_o  <= 1'b0;
    end else begin
      bus_cmd_o <= preq_valid_i ? cmd_p : BC_NONE;
      wb_o      <= preq_valid_i & wb_p;
      flush_o   <= !preq_valid_i & snp_valid_i & fl_s;
      shared_o  <= !preq_valid_i & snp_valid_i & sh_s;
    end
  end

  assign st_rd_o = st_raw[st_rd_idx_i];

  // ---------------- assertions ----------------
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preq_valid_i && !snp_valid_i |=> bus_cmd_o == BC_NONE && !wb_o && !flush_o && !shared_o);

  assert_upgr_from_so_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preq_valid_i && preq_op_i == OP_WRITE && (cur_p == ST_S || cur_p == ST_O)
    |=> bus_cmd_o == BC_UPGR);

  assert_snprd_m_no_wb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preq_valid_i && snp_valid_i && snp_cmd_i == BC_RD && cur_s == ST_M
    |=> flush_o && shared_o && !wb_o);

  assert_evict_dirty_wb_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preq_valid_i && preq_op_i == OP_EVICT && (cur_p == ST_M || cur_p == ST_O)
    |=> bus_cmd_o == BC_WB && wb_o);

  assert_wb_with_cmd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_o |-> bus_cmd_o == BC_WB);

  assert_no_own_from_es_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preq_valid_i && snp_valid_i && (cur_s == ST_E || cur_s == ST_S)
    |=> line_st[$past(snp_idx_i)] != ST_O);

  assert_snp_wb_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !preq_valid_i && snp_valid_i && snp_cmd_i == BC_WB
    |=> !flush_o && !shared_o && line_st[$past(snp_idx_i)] == $past(cur_s));

  assert_no_req_overlap_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(preq_valid_i && snp_valid_i));
endmodule

// File: tb/tb_moesi_coh_ctrl.sv
`timescale 1ns/1ps
module tb_moesi_coh_ctrl;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_ni;
  logic          preq_valid, bus_shared, bus_src, snp_valid;
  logic [1:0]    preq_op;
  logic [2:0]    snp_cmd;
  logic [IW-1:0] preq_idx, snp_idx, st_rd_idx;

  logic [2:0] st_a, cmd_a, cmd_b;
  logic [1:0] st_b;
  logic wb_a, fl_a, sh_a, wb_b, fl_b, sh_b;

  moesi_coh_ctrl #(.NUM_LINES(N), .HAS_EXCL(1'b1), .HANDOFF(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .preq_valid_i(preq_valid), .preq_op_i(preq_op),
    .preq_idx_i(preq_idx), .bus_shared_i(bus_shared), .bus_src_i(bus_src),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_idx_i(snp_idx),
    .st_rd_idx_i(st_rd_idx), .st_rd_o(st_a), .bus_cmd_o(cmd_a), .wb_o(wb_a),
    .flush_o(fl_a), .shared_o(sh_a));

  moesi_coh_ctrl #(.NUM_LINES(N), .HAS_EXCL(1'b0), .HANDOFF(1'b1)) dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .preq_valid_i(preq_valid), .preq_op_i(preq_op),
    .preq_idx_i(preq_idx), .bus_shared_i(bus_shared), .bus_src_i(bus_src),
    .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_idx_i(snp_idx),
    .st_rd_idx_i(st_rd_idx), .st_rd_o(st_b), .bus_cmd_o(cmd_b), .wb_o(wb_b),
    .flush_o(fl_b), .shared_o(sh_b));

  // encodings: states I0 S1 O2 M3 E4; cmds none0 rd1 rdx2 upgr3 wb4; ops rd0 wr1 ev2
  localparam logic [2:0] I = 0, S = 1, O = 2, M = 3, E = 4;
  localparam logic [2:0] C0 = 0, CRD = 1, CRDX = 2, CUP = 3, CWB = 4;
  localparam int K_NOP = 0, K_PROC = 1, K_SNP = 2;

  typedef struct {
    int         due;
    logic [8:0] exp;
    string      tag;
  } item_t;

  item_t qa[$];
  item_t qb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [8:0] ex(logic [2:0] c, logic w, logic f, logic s, logic [2:0] st);
    return {c, w, f, s, st};
  endfunction

  task automatic step(int kind, logic [2:0] code, int idx, logic shr, logic src,
                      logic [8:0] ea, logic [8:0] eb, string tag);
    item_t it;
    @(posedge clk); #2;
    preq_valid = (kind == K_PROC);
    snp_valid  = (kind == K_SNP);
    preq_op    = code[1:0];
    snp_cmd    = code;
    preq_idx   = IW'(idx);
    snp_idx    = IW'(idx);
    st_rd_idx  = IW'(idx);
    bus_shared = shr;
    bus_src    = src;
    it.due = cyc + 1; it.tag = tag;
    it.exp = ea; qa.push_back(it);
    it.exp = eb; qb.push_back(it);
    @(posedge clk); #2;
    preq_valid = 1'b0; snp_valid = 1'b0; bus_shared = 1'b0; bus_src = 1'b0;
  endtask

  item_t ma, mb;
  logic [8:0] act;
  always @(posedge clk) begin
    #1;
    while (qa.size() > 0 && qa[0].due == cyc) begin
      ma = qa.pop_front();
      act = {cmd_a, wb_a, fl_a, sh_a, st_a};
      checks++;
      if (act !== ma.exp) begin
        errors++;
        $display("FAIL %s dut: got cmd=%0d wb=%0d fl=%0d sh=%0d st=%0d exp cmd=%0d wb=%0d fl=%0d sh=%0d st=%0d",
          ma.tag, act[8:6], act[5], act[4], act[3], act[2:0],
          ma.exp[8:6], ma.exp[5], ma.exp[4], ma.exp[3], ma.exp[2:0]);
      end
    end
    while (qb.size() > 0 && qb[0].due == cyc) begin
      mb = qb.pop_front();
      act = {cmd_b, wb_b, fl_b, sh_b, 1'b0, st_b};
      checks++;
      if (act !== mb.exp) begin
        errors++;
        $display("FAIL %s dut_b: got cmd=%0d wb=%0d fl=%0d sh=%0d st=%0d exp cmd=%0d wb=%0d fl=%0d sh=%0d st=%0d",
          mb.tag, act[8:6], act[5], act[4], act[3], act[2:0],
          mb.exp[8:6], mb.exp[5], mb.exp[4], mb.exp[3], mb.exp[2:0]);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    preq_valid = 0; snp_valid = 0; bus_shared = 0; bus_src = 0;
    preq_op = 0; snp_cmd = 0; preq_idx = 0; snp_idx = 0; st_rd_idx = 0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state and idle outputs
    step(K_NOP, 0, 0, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R1 reset");
    // R2/R11 read miss, no sharers
    step(K_PROC, 0, 1, 0, 0, ex(CRD,0,0,0,E), ex(CRD,0,0,0,S), "R2 R11 read miss alone");
    // R13 read hit
    step(K_PROC, 0, 1, 0, 0, ex(C0,0,0,0,E), ex(C0,0,0,0,S), "R13 read hit");
    // R3 write on E silent, R4 write on S upgrades
    step(K_PROC, 1, 1, 0, 0, ex(C0,0,0,0,M), ex(CUP,0,0,0,M), "R3 R4 write hit");
    // migratory hand-over: R5
    step(K_SNP, CRD, 1, 0, 0, ex(C0,0,1,1,O), ex(C0,0,1,1,S), "R5 snoop read on M");
    // R6 owner keeps sourcing
    step(K_SNP, CRD, 1, 0, 0, ex(C0,0,1,1,O), ex(C0,0,0,1,S), "R6 snoop read on O");
    // R4 write on O
    step(K_PROC, 1, 1, 0, 0, ex(CUP,0,0,0,M), ex(CUP,0,0,0,M), "R4 write on O");
    // R7 snoop rdx on M
    step(K_SNP, CRDX, 1, 0, 0, ex(C0,0,1,0,I), ex(C0,0,1,0,I), "R7 snoop rdx on M");
    // R10/R9 read miss with data sourced by an owner
    step(K_PROC, 0, 2, 1, 1, ex(CRD,0,0,0,S), ex(CRD,0,0,0,O), "R10 R9 read miss sourced");
    step(K_SNP, CRD, 2, 0, 0, ex(C0,0,0,1,S), ex(C0,0,1,1,S), "R6 R10 snoop read after inherit");
    // R2 read miss with sharers
    step(K_PROC, 0, 3, 1, 0, ex(CRD,0,0,0,S), ex(CRD,0,0,0,S), "R2 read miss shared");
    step(K_SNP, CUP, 3, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R7 snoop upgr on S");
    // R3 write miss and write hit on M
    step(K_PROC, 1, 4, 0, 0, ex(CRDX,0,0,0,M), ex(CRDX,0,0,0,M), "R3 write miss");
    step(K_PROC, 1, 4, 0, 0, ex(C0,0,0,0,M), ex(C0,0,0,0,M), "R3 write hit on M");
    // R8 evictions
    step(K_PROC, 2, 4, 0, 0, ex(CWB,1,0,0,I), ex(CWB,1,0,0,I), "R8 evict M");
    step(K_PROC, 0, 5, 0, 0, ex(CRD,0,0,0,E), ex(CRD,0,0,0,S), "R2 R11 read miss line5");
    step(K_PROC, 2, 5, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R8 evict clean");
    // R12 snoops to Invalid and writebacks ignored
    step(K_SNP, CWB, 6, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R12 snoop wb on I");
    step(K_SNP, CRD, 6, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R12 snoop read on I");
    // migratory end: one writeback from the owner only
    step(K_PROC, 1, 7, 0, 0, ex(CRDX,0,0,0,M), ex(CRDX,0,0,0,M), "R3 write miss line7");
    step(K_SNP, CRD, 7, 0, 0, ex(C0,0,1,1,O), ex(C0,0,1,1,S), "R5 snoop read line7");
    step(K_SNP, CWB, 7, 0, 0, ex(C0,0,0,0,O), ex(C0,0,0,0,S), "R12 snoop wb on valid");
    step(K_PROC, 2, 7, 0, 0, ex(CWB,1,0,0,I), ex(C0,0,0,0,I), "R8 evict O");
    // R6/R9 snoop read on E
    step(K_PROC, 0, 8, 0, 0, ex(CRD,0,0,0,E), ex(CRD,0,0,0,S), "R2 read miss line8");
    step(K_SNP, CRD, 8, 0, 0, ex(C0,0,0,1,S), ex(C0,0,0,1,S), "R6 R9 snoop read on E");
    // R7 snoop rdx on O
    step(K_PROC, 1, 9, 0, 0, ex(CRDX,0,0,0,M), ex(CRDX,0,0,0,M), "R3 write miss line9");
    step(K_SNP, CRD, 9, 0, 0, ex(C0,0,1,1,O), ex(C0,0,1,1,S), "R5 snoop read line9");
    step(K_SNP, CRDX, 9, 0, 0, ex(C0,0,1,0,I), ex(C0,0,0,0,I), "R7 snoop rdx on O");
    // R7 snoop upgr on E
    step(K_PROC, 0, 10, 0, 0, ex(CRD,0,0,0,E), ex(CRD,0,0,0,S), "R2 read miss line10");
    step(K_SNP, CUP, 10, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R7 snoop upgr on E");
    // R1 idle after activity, untouched line still Invalid
    step(K_NOP, 0, 15, 0, 0, ex(C0,0,0,0,I), ex(C0,0,0,0,I), "R1 idle");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule